// File: doc/BRIEF.md
# Vector Tail and Mask Policy Merge

This block sits at the write-back end of a vector unit with 128-bit registers. For one destination register of a group, it decides for every byte, or for every bit, whether to take the freshly computed result or the old register contents, or to force all ones. That choice depends on the active length, the element width, the position of the register in its group, the mask register v0, and the tail and mask policy bits. Two separate fill enables allow agnostic positions to be written as all ones. When an enable is clear, those positions keep their old contents.

The merge is purely combinational. The surrounding pipeline supplies the operation class: ordinary element result, mask-producing result, mask load, or scalar-destination instruction. For loads, it also supplies an optional element-width override. When a fault-only-first load stops early, it supplies the faulting element index. Computing the results, accessing memory and detecting faults all happen elsewhere.

Top module: `vtail_mask_merge`

## Requirements
- R1: In element mode (op_kind 0), an element is active when unmasked is 1 or bit i of mask_reg is 1. Element index i is group_reg*(128/w)+p, where w is the width and p is the position in the register. Every byte of an active element below the length takes new_data.
- R2: When tail_agn is 0, every byte of an element with index at or above the length keeps old_data, whatever the fill enables are set to.
- R3: When tail_agn is 1, tail bytes become 8'hFF if tail_fill_en is 1 and keep old_data if it is 0.
- R4: An inactive body element becomes all ones when both mask_agn and mask_fill_en are 1. Otherwise it keeps old_data. When unmasked is 1, no element is inactive.
- R5: A register of a group whose first element index is at or above the length is wholly tail.
- R6: Mask-producing results (op_kind 1) are merged per bit and ignore the mask. A bit below vec_len takes new_data. A bit at or above vec_len is tail-agnostic: it is 1 when tail_fill_en is 1 and keeps old_data otherwise.
- R7: Mask loads (op_kind 2) use ceil(vec_len/8) bytes of new_data and ignore the mask and width fields. The remaining bytes are tail-agnostic: they are 8'hFF when tail_fill_en is 1 and keep old_data otherwise.
- R8: When ff_fault is 1 and ff_index is below vec_len, the element length becomes ff_index. Otherwise it stays vec_len.
- R9: A scalar-destination instruction (op_kind 3) leaves the register unchanged: merged equals old_data.
- R10: The width code is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. When eew_override is 1, eew_code is used instead of sew_code for element indexing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_kind | input | 2 | 0 element, 1 mask result, 2 mask load, 3 scalar destination |
| sew_code | input | 2 | Selected element width code |
| eew_override | input | 1 | Use the load's encoded width |
| eew_code | input | 2 | Encoded load width code |
| group_reg | input | 3 | Register position within its group |
| vec_len | input | 8 | Vector length in elements |
| ff_fault | input | 1 | Fault-only-first load stopped early |
| ff_index | input | 8 | Element index of the reported fault |
| unmasked | input | 1 | Instruction is not masked |
| tail_agn | input | 1 | Tail-agnostic policy |
| mask_agn | input | 1 | Mask-agnostic policy |
| tail_fill_en | input | 1 | Fill agnostic tail with ones |
| mask_fill_en | input | 1 | Fill agnostic inactive elements with ones |
| old_data | input | 128 | Previous register contents |
| new_data | input | 128 | Computed result |
| mask_reg | input | 128 | Contents of v0 |
| merged | output | 128 | Register value to write back |

## Verification
Two functions can meet on the same element: the tail rule and the inactive rule. This happens when an element lies at or past the length and its v0 bit is also 0. The vectors provoke it by combining fills that differ with masks whose zero bits extend past the length. For example, mask agnostic with fill and tail undisturbed must leave such an element unchanged rather than filled. A second meeting point is a fault trim that falls inside the masked region. Here the bench expects the tail treatment to win over the mask treatment. Every expected value comes from a bit-serial model that walks element indices rather than byte lanes.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
  localparam int VLEN_DEF      = 128;
  localparam int MAX_GROUP_DEF = 8;

  typedef enum logic [1:0] {
    OP_ELEM    = 2'd0,
    OP_MASKGEN = 2'd1,
    OP_MASKLD  = 2'd2,
    OP_SCALAR  = 2'd3
  } vtm_op_e;

  // log2 of element bytes; code 3 is treated as 32-bit
  function automatic logic [1:0] width_log2(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  // length after an early-stopping load
  function automatic int trimmed_len(input int vl, input logic fault, input int k);
    return (fault && k < vl) ? k : vl;
  endfunction

  // bytes used by a mask load
  function automatic int mask_load_bytes(input int vl);
    return (vl + 7) / 8;
  endfunction

  // element index covering a byte lane of a grouped register
  function automatic int elem_of_lane(input int grp, input int lane, input int lg,
                                      input int vbytes);
    return grp * (vbytes >> lg) + (lane >> lg);
  endfunction
endpackage

// File: rtl/vtm_len.sv
module vtm_len #(
  parameter int LEN_W = 8
) (
  input  logic [1:0]       sew_code,
  input  logic             eew_override,
  input  logic [1:0]       eew_code,
  input  logic [LEN_W-1:0] vec_len,
  input  logic             ff_fault,
  input  logic [LEN_W-1:0] ff_index,
  output logic [1:0]       lg,
  output logic [LEN_W-1:0] elem_len,
  output logic [LEN_W-1:0] mld_len
);
  import vtm_pkg::*;

  always_comb begin
    lg       = width_log2(eew_override ? eew_code : sew_code);
    elem_len = LEN_W'(trimmed_len(int'(vec_len), ff_fault, int'(ff_index)));
    mld_len  = LEN_W'(mask_load_bytes(int'(vec_len)));
  end

  always_comb begin
    assert_trim_le_R8: assert (elem_len <= vec_len)
      else $error("trimmed length exceeds vec_len");
    if (ff_fault && ff_index < vec_len) begin
      assert_trim_hit_R8: assert (elem_len == ff_index)
        else $error("fault index not applied");
    end
    assert_mld_cover_R7: assert (int'(mld_len) * 8 >= int'(vec_len) &&
                                 int'(mld_len) * 8 < int'(vec_len) + 8)
      else $error("mask load byte count off");
  end
endmodule

// File: rtl/vtm_lane.sv
module vtm_lane #(
  parameter int VLEN   = 128,
  parameter int LANE   = 0,
  parameter int GIDX_W = 3,
  parameter int LEN_W  = 8
) (
  input  logic [1:0]        lg,
  input  logic [GIDX_W-1:0] group_reg,
  input  logic [LEN_W-1:0]  elem_len,
  input  logic              unmasked,
  input  logic [VLEN-1:0]   mask_reg,
  output logic              is_tail,
  output logic              is_inactive
);
  import vtm_pkg::*;

  localparam int VBYTES = VLEN / 8;
  localparam int IDX_W  = $clog2(VLEN);

  int idx;

  always_comb begin
    idx         = elem_of_lane(int'(group_reg), LANE, int'(lg), VBYTES);
    is_tail     = idx >= int'(elem_len);
    is_inactive = !unmasked && ((idx < VLEN) ? !mask_reg[IDX_W'(idx)] : 1'b1);
  end
endmodule

// File: rtl/vtm_maskdest.sv
module vtm_maskdest #(
  parameter int VLEN  = 128,
  parameter int LEN_W = 8
) (
  input  logic             is_mld,
  input  logic [LEN_W-1:0] vec_len,
  input  logic [LEN_W-1:0] mld_len,
  input  logic             tail_fill_en,
  input  logic [VLEN-1:0]  old_data,
  input  logic [VLEN-1:0]  new_data,
  output logic [VLEN-1:0]  mask_out
);
  logic [VLEN-1:0] keep_bit;

  always_comb begin
    for (int b = 0; b < VLEN; b++) begin
      keep_bit[b] = is_mld ? ((b >> 3) < int'(mld_len)) : (b < int'(vec_len));
      mask_out[b] = keep_bit[b] ? new_data[b] : (tail_fill_en | old_data[b]);
    end
  end

  always_comb begin
    if (!is_mld && tail_fill_en && int'(vec_len) < VLEN) begin
      assert_mask_tail_ones_R6: assert (mask_out[VLEN-1])
        else $error("mask tail not filled");
    end
    assert_first_bit_R7: assert (keep_bit[0] == (vec_len != '0))
      else $error("first destination bit policy wrong");
  end
endmodule

// File: rtl/vtail_mask_merge.sv
module vtail_mask_merge #(
  parameter  int VLEN      = vtm_pkg::VLEN_DEF,
  parameter  int MAX_GROUP = vtm_pkg::MAX_GROUP_DEF,
  localparam int LEN_W     = $clog2(VLEN * MAX_GROUP / 8 + 1),
  localparam int GIDX_W    = $clog2(MAX_GROUP)
) (
  input  logic [1:0]        op_kind,
  input  logic [1:0]        sew_code,
  input  logic              eew_override,
  input  logic [1:0]        eew_code,
  input  logic [GIDX_W-1:0] group_reg,
  input  logic [LEN_W-1:0]  vec_len,
  input  logic              ff_fault,
  input  logic [LEN_W-1:0]  ff_index,
  input  logic              unmasked,
  input  logic              tail_agn,
  input  logic              mask_agn,
  input  logic              tail_fill_en,
  input  logic              mask_fill_en,
  input  logic [VLEN-1:0]   old_data,
  input  logic [VLEN-1:0]   new_data,
  input  logic [VLEN-1:0]   mask_reg,
  output logic [VLEN-1:0]   merged
);
  import vtm_pkg::*;

  localparam int VBYTES = VLEN / 8;

  logic [1:0]       lg;
  logic [LEN_W-1:0] elem_len;
  logic [LEN_W-1:0] mld_len;
  logic [VBYTES-1:0] tail_lane;
  logic [VBYTES-1:0] inact_lane;
  logic [VLEN-1:0]  mask_out;
  logic [VLEN-1:0]  elem_out;
  logic             tail_ones;
  logic             inact_ones;

  vtm_len #(.LEN_W(LEN_W)) u_len (
    .sew_code     (sew_code),
    .eew_override (eew_override),
    .eew_code     (eew_code),
    .vec_len      (vec_len),
    .ff_fault     (ff_fault),
    .ff_index     (ff_index),
    .lg           (lg),
    .elem_len     (elem_len),
    .mld_len      (mld_len)
  );

  for (genvar k = 0; k < VBYTES; k++) begin : g_lane
    vtm_lane #(.VLEN(VLEN), .LANE(k), .GIDX_W(GIDX_W), .LEN_W(LEN_W)) u_lane (
      .lg          (lg),
      .group_reg   (group_reg),
      .elem_len    (elem_len),
      .unmasked    (unmasked),
      .mask_reg    (mask_reg),
      .is_tail     (tail_lane[k]),
      .is_inactive (inact_lane[k])
    );
  end

  vtm_maskdest #(.VLEN(VLEN), .LEN_W(LEN_W)) u_maskdest (
    .is_mld       (op_kind == OP_MASKLD),
    .vec_len      (vec_len),
    .mld_len      (mld_len),
    .tail_fill_en (tail_fill_en),
    .old_data     (old_data),
    .new_data     (new_data),
    .mask_out     (mask_out)
  );

  assign tail_ones  = tail_agn & tail_fill_en;
  assign inact_ones = mask_agn & mask_fill_en;

  always_comb begin
    for (int k = 0; k < VBYTES; k++) begin
      if (tail_lane[k])
        elem_out[8*k +: 8] = tail_ones ? 8'hFF : old_data[8*k +: 8];
      else if (inact_lane[k])
        elem_out[8*k +: 8] = inact_ones ? 8'hFF : old_data[8*k +: 8];
      else
        elem_out[8*k +: 8] = new_data[8*k +: 8];
    end
  end

  always_comb begin
    case (op_kind)
      OP_ELEM:               merged = elem_out;
      OP_MASKGEN, OP_MASKLD: merged = mask_out;
      default:               merged = old_data;
    endcase
  end

  always_comb begin
    if (op_kind == OP_SCALAR) begin
      assert_scalar_hold_R9: assert (merged == old_data)
        else $error("scalar destination modified register");
    end
    for (int k = 0; k < VBYTES - 1; k++) begin
      assert_tail_monotone_R2: assert (!tail_lane[k] || tail_lane[k+1])
        else $error("tail lanes not contiguous");
    end
    if (unmasked) begin
      assert_unmasked_active_R4: assert (inact_lane == '0)
        else $error("inactive lane while unmasked");
    end
    if (int'(group_reg) * (VBYTES >> lg) >= int'(elem_len)) begin
      assert_group_tail_R5: assert (&tail_lane)
        else $error("register past length not wholly tail");
    end
    if (op_kind == OP_ELEM && !tail_ones) begin
      for (int k = 0; k < VBYTES; k++) begin
        if (tail_lane[k]) begin
          assert_tail_keep_R3: assert (merged[8*k +: 8] == old_data[8*k +: 8])
            else $error("undisturbed tail byte changed");
        end
      end
    end
  end
endmodule

// File: tb/vtail_mask_merge_bench.sv
module vtail_mask_merge_bench;
  typedef struct packed {
    logic [1:0]   op;
    logic [1:0]   sew;
    logic         ovr;
    logic [1:0]   eew;
    logic [2:0]   grp;
    logic [7:0]   vl;
    logic         flt;
    logic [7:0]   fidx;
    logic         vm;
    logic         ta;
    logic         ma;
    logic         fta;
    logic         fma;
    logic [127:0] old;
    logic [127:0] nw;
    logic [127:0] msk;
  } stim_t;

  localparam logic [127:0] OLDP = 128'hA5A5_5A5A_C3C3_3C3C_9696_6969_F0F0_0F0F;
  localparam logic [127:0] NEWP = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam int NVEC = 16;

  localparam stim_t TABLE [NVEC] = '{
    // R4 R2: e32 vl3 tu ma, fills on
    '{2'd0,2'd2,1'b0,2'd0,3'd0,8'd3,1'b0,8'd0,1'b0,1'b0,1'b1,1'b1,1'b1,128'h0,{4{32'h2}},128'h1},
    // R4: same, mask fill off
    '{2'd0,2'd2,1'b0,2'd0,3'd0,8'd3,1'b0,8'd0,1'b0,1'b0,1'b1,1'b1,1'b0,128'h0,{4{32'h2}},128'h1},
    // R3: ta mu, tail fill on
    '{2'd0,2'd2,1'b0,2'd0,3'd0,8'd3,1'b0,8'd0,1'b0,1'b1,1'b0,1'b1,1'b1,128'h0,{4{32'h3}},128'h1},
    // R3: ta, tail fill off
    '{2'd0,2'd2,1'b0,2'd0,3'd0,8'd3,1'b0,8'd0,1'b0,1'b1,1'b0,1'b0,1'b1,OLDP,{4{32'h3}},128'h1},
    // R6: mask result vl14 fill on
    '{2'd1,2'd0,1'b0,2'd0,3'd0,8'd14,1'b0,8'd0,1'b0,1'b0,1'b1,1'b1,1'b1,OLDP,NEWP,128'h0},
    // R6: mask result vl14 fill off
    '{2'd1,2'd0,1'b0,2'd0,3'd0,8'd14,1'b0,8'd0,1'b0,1'b0,1'b1,1'b0,1'b1,OLDP,NEWP,128'h0},
    // R7: mask load vl31, width/group fields ignored
    '{2'd2,2'd2,1'b0,2'd0,3'd3,8'd31,1'b0,8'd0,1'b0,1'b0,1'b1,1'b1,1'b1,OLDP,NEWP,128'h0},
    // R10: sew8 overridden to 16, mask 0x0d
    '{2'd0,2'd0,1'b1,2'd1,3'd0,8'd5,1'b0,8'd0,1'b0,1'b1,1'b1,1'b1,1'b1,OLDP,NEWP,128'hd},
    // R5: e16 second register, vl5
    '{2'd0,2'd1,1'b0,2'd0,3'd1,8'd5,1'b0,8'd0,1'b0,1'b1,1'b1,1'b1,1'b1,OLDP,NEWP,128'hd},
    // R8: e8 vl31 fault at 3
    '{2'd0,2'd0,1'b0,2'd0,3'd0,8'd31,1'b1,8'd3,1'b0,1'b1,1'b1,1'b1,1'b1,OLDP,NEWP,128'hf},
    // R1: e32 second register vl6 mask 0x1d
    '{2'd0,2'd2,1'b0,2'd0,3'd1,8'd6,1'b0,8'd0,1'b0,1'b1,1'b1,1'b1,1'b1,OLDP,NEWP,128'h1d},
    // R9: scalar destination
    '{2'd3,2'd0,1'b0,2'd0,3'd0,8'd8,1'b0,8'd0,1'b0,1'b1,1'b1,1'b1,1'b1,OLDP,NEWP,128'h0},
    // R1: unmasked e8 last register vl128
    '{2'd0,2'd0,1'b0,2'd0,3'd7,8'd128,1'b0,8'd0,1'b1,1'b1,1'b1,1'b1,1'b1,OLDP,NEWP,128'h0},
    // R8: fault at 0, tail fill off
    '{2'd0,2'd0,1'b0,2'd0,3'd0,8'd20,1'b1,8'd0,1'b1,1'b1,1'b1,1'b0,1'b1,OLDP,NEWP,128'h0},
    // R8: fault index beyond vl has no effect
    '{2'd0,2'd0,1'b0,2'd0,3'd0,8'd10,1'b1,8'd200,1'b1,1'b1,1'b1,1'b1,1'b1,OLDP,NEWP,128'h0},
    // R7: mask load vl0, all tail
    '{2'd2,2'd0,1'b0,2'd0,3'd0,8'd0,1'b0,8'd0,1'b0,1'b0,1'b0,1'b1,1'b0,OLDP,NEWP,128'h0}
  };

  string tags [NVEC] = '{"R4","R4","R3","R3","R6","R6","R7","R10",
                         "R5","R8","R1","R9","R1","R8","R8","R7"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  stim_t cur = '0;
  logic [127:0] merged;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vtail_mask_merge u_vtail_mask_merge (
    .op_kind      (cur.op),
    .sew_code     (cur.sew),
    .eew_override (cur.ovr),
    .eew_code     (cur.eew),
    .group_reg    (cur.grp),
    .vec_len      (cur.vl),
    .ff_fault     (cur.flt),
    .ff_index     (cur.fidx),
    .unmasked     (cur.vm),
    .tail_agn     (cur.ta),
    .mask_agn     (cur.ma),
    .tail_fill_en (cur.fta),
    .mask_fill_en (cur.fma),
    .old_data     (cur.old),
    .new_data     (cur.nw),
    .mask_reg     (cur.msk),
    .merged       (merged)
  );

  // bit-serial reference walking element indices
  function automatic logic [127:0] model(input stim_t s);
    logic [127:0] r;
    int w, per, len, nbytes, ei;
    r = s.old;
    case (s.op)
      2'd3: r = s.old;
      2'd1: for (int b = 0; b < 128; b++)
              r[b] = (b < int'(s.vl)) ? s.nw[b] : (s.fta ? 1'b1 : s.old[b]);
      2'd2: begin
        nbytes = (int'(s.vl) + 7) / 8;
        for (int b = 0; b < 128; b++)
          r[b] = (b / 8 < nbytes) ? s.nw[b] : (s.fta ? 1'b1 : s.old[b]);
      end
      default: begin
        w   = 8 << (s.ovr ? s.eew : s.sew);
        per = 128 / w;
        len = (s.flt && s.fidx < s.vl) ? int'(s.fidx) : int'(s.vl);
        for (int b = 0; b < 128; b++) begin
          ei = int'(s.grp) * per + b / w;
          if (ei >= len)                  r[b] = (s.ta && s.fta) ? 1'b1 : s.old[b];
          else if (!s.vm && !s.msk[ei])   r[b] = (s.ma && s.fma) ? 1'b1 : s.old[b];
          else                            r[b] = s.nw[b];
        end
      end
    endcase
    return r;
  endfunction

  task automatic run(input stim_t s, input string tag);
    logic [127:0] exp;
    @(negedge clk);
    cur = s;
    #2;
    exp = model(s);
    checks++;
    if (merged !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, merged, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    stim_t s;
    // reset state: scalar idle, register must pass through (R9)
    s = TABLE[11];
    s.old = NEWP;
    run(s, "R9 reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int n = 0; n < NVEC; n++) run(TABLE[n], tags[n]);

    // R2: tail undisturbed with both fills on, e16
    s = TABLE[7];
    s.ovr = 1'b0; s.sew = 2'd1; s.ta = 1'b0;
    run(s, "R2");
    // R6: mask register contents ignored for mask results
    s = TABLE[4];
    s.msk = '1; s.vm = 1'b0;
    run(s, "R6 mask ignored");
    // R4 with R8: fault trim inside masked-off region, tail wins
    s = TABLE[9];
    s.msk = 128'h3; s.fta = 1'b0; s.ma = 1'b1; s.fma = 1'b1;
    run(s, "R8 trim vs mask");
    // R1: e16 active elements, mask alternating
    s = TABLE[12];
    s.sew = 2'd1; s.grp = 3'd2; s.vm = 1'b0; s.msk = {64{2'b10}};
    s.vl = 8'd22;
    run(s, "R1 e16 alt");
    finish_run();
  end
endmodule